// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block owns a pool of 256-byte buffer pages that transmit and receive frames share inside an Ethernet controller. A host drives it through a command byte. The top three bits of that byte select an operation and the low five bits carry a page count. Through these commands the host can claim a run of pages for a packet, free a packet, queue a packet for transmit, drop the head of the receive queue, or release that head and return its pages. A packet is named by the index of its first page. A small table records how many pages each live packet holds.

The MAC asks for receive buffers through a one-cycle request port and gets an acknowledge on the next cycle. A granted receive packet joins the receive queue. A transmit-completion strobe pops the transmit queue. While the auto-release input is high, the popped packet's pages also return to the pool. Freeing a packet takes one cycle per page, and a busy flag shows while that runs. The host can also read the free and total page counts, the last allocation result and both queue heads.

Top module: `pa_alloc_top`

## Requirements
- R1: Command byte bits 7:5 select the operation: 0 nop, 1 allocate, 2 reset, 3 remove receive head, 4 release receive head, 5 free the packet in the packet-number register, 6 enqueue for transmit, 7 reset the transmit queue. For allocate, bits 4:0 hold pages minus one. The block claims the lowest-numbered run of free pages that is long enough. The packet number is the run's first page, and `alloc_result_o` returns it with bit 7 clear on the cycle after the command.
- R2: If no run is long enough, `alloc_result_o` reads 0x80 and the free count does not change.
- R3: `mem_info_o` carries the free page count in bits 15:8 and the total page count in bits 7:0.
- R4: `queue_heads_o` carries the receive head in bits 14:8 and the transmit head in bits 6:0. Bit 15 is set when the receive queue is empty and bit 7 when the transmit queue is empty. A head field reads 0 while its queue is empty.
- R5: Freeing an N-page packet sets busy (`cmd_status_o` bit 0) after the starting edge. One page returns to the pool on each of the following N edges, and busy clears once the last page is back.
- R6: While busy, host commands and transmit completions are ignored. A command written in the same cycle as a transmit completion is also dropped.
- R7: Command 3 pops the receive head and keeps its pages allocated. Command 4 pops the head and frees its pages.
- R8: Command 6 pushes the packet-number register onto the transmit queue, and packets leave in the order they were pushed.
- R9: A transmit completion pops the transmit head. It frees that packet's pages only when `auto_release_i` is high.
- R10: Command 7 empties the transmit queue and leaves all pages and the receive queue as they were.
- R11: Command 2 returns every page to the pool and empties both queues.
- R12: Every receive request is acknowledged one cycle later. `rx_alloc_ok_o` is high and `rx_alloc_pkt_o` holds the first page of the granted run only when the block is idle, no command or completion arrives in that cycle, and a long enough run exists. A grant pushes the packet onto the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_wdata_i | input | 8 | Command byte: operation in 7:5, pages minus one in 4:0 |
| pnr_we_i | input | 1 | Packet-number register write strobe |
| pnr_wdata_i | input | 7 | Packet number to free or enqueue |
| cmd_status_o | output | 8 | Bit 0 busy, other bits zero |
| alloc_result_o | output | 8 | Last host allocation: packet number, bit 7 failure |
| queue_heads_o | output | 16 | Receive and transmit queue heads with empty flags |
| mem_info_o | output | 16 | Free pages (high byte), total pages (low byte) |
| rx_alloc_req_i | input | 1 | Receive buffer request from the MAC |
| rx_alloc_pages_i | input | 5 | Requested pages minus one |
| rx_alloc_ack_o | output | 1 | Request answered |
| rx_alloc_ok_o | output | 1 | Request granted |
| rx_alloc_pkt_o | output | 7 | Granted packet number |
| tx_done_i | input | 1 | Transmit of the queue head finished |
| auto_release_i | input | 1 | Free the completed packet's pages |

## Verification
Allocation results, queue changes, the grant acknowledge and the start of busy all appear one edge after the input that causes them. A freed page shows in the free count one edge after each busy cycle, so an N-page free is complete N+1 edges after the command. The bench drives inputs on falling edges and samples on the next falling edge. For releases it then counts falling edges one by one and checks the free count and busy at the exact edge where each is due.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_ALLOC      = 3'd1,
    OP_RESET      = 3'd2,
    OP_RX_REMOVE  = 3'd3,
    OP_RX_RELEASE = 3'd4,
    OP_FREE_PNR   = 3'd5,
    OP_TX_ENQ     = 3'd6,
    OP_TX_RESET   = 3'd7
  } pa_op_e;
endpackage

// File: rtl/pa_run_finder.sv
module pa_run_finder #(
  parameter int NUM_PAGES = 16,
  parameter int PW = $clog2(NUM_PAGES)
) (
  input  logic [NUM_PAGES-1:0] used_i,
  input  logic [5:0]           n_i,
  output logic                 found_o,
  output logic [PW-1:0]        start_o
);
  logic [NUM_PAGES-1:0] fit;

  for (genvar s = 0; s < NUM_PAGES; s++) begin : g_start
    logic ok;
    always_comb begin
      ok = (s + int'(n_i)) <= NUM_PAGES;
      for (int k = 0; k < NUM_PAGES; k++)
        if (k >= s && k < s + int'(n_i) && used_i[k]) ok = 1'b0;
    end
    assign fit[s] = ok;
  end

  // lowest start wins
  always_comb begin
    found_o = 1'b0;
    start_o = '0;
    for (int s = NUM_PAGES - 1; s >= 0; s--)
      if (fit[s]) begin
        found_o = 1'b1;
        start_o = PW'(s);
      end
  end
endmodule

// File: rtl/pa_pkt_fifo.sv
module pa_pkt_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [AW-1:0]   rd_q, wr_q;
  logic [CNTW-1:0] cnt_q;
  logic            do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (cnt_q != CNTW'(DEPTH) || do_pop);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNTW'(DEPTH));
endmodule

// File: rtl/pa_alloc_top.sv
module pa_alloc_top
  import pa_pkg::*;
#(
  parameter int NUM_PAGES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [7:0]  cmd_wdata_i,
  input  logic        pnr_we_i,
  input  logic [6:0]  pnr_wdata_i,
  output logic [7:0]  cmd_status_o,
  output logic [7:0]  alloc_result_o,
  output logic [15:0] queue_heads_o,
  output logic [15:0] mem_info_o,
  input  logic        rx_alloc_req_i,
  input  logic [4:0]  rx_alloc_pages_i,
  output logic        rx_alloc_ack_o,
  output logic        rx_alloc_ok_o,
  output logic [6:0]  rx_alloc_pkt_o,
  input  logic        tx_done_i,
  input  logic        auto_release_i
);
  localparam int PW = $clog2(NUM_PAGES);
  localparam int CW = $clog2(NUM_PAGES + 1);

  logic [NUM_PAGES-1:0] used_q, claim;
  logic [CW-1:0]        cnt_q [NUM_PAGES];
  logic [PW-1:0]        rel_pg_q;
  logic [CW-1:0]        rel_left_q;
  logic [7:0]           res_q;
  logic [6:0]           pnr_q;
  logic                 ack_q, ok_q;
  logic [PW-1:0]        pkt_q;

  logic          busy, cmd_v, tx_evt, rx_v, host_alloc, grant, pnr_ok;
  pa_op_e        op;
  logic [5:0]    n_host, n_rx, n_sel;
  logic          found;
  logic [PW-1:0] start;
  logic [CW-1:0] used_cnt, free_cnt;
  logic          rel_start;
  logic [PW-1:0] rel_pkt;

  logic [PW-1:0] rx_head, tx_head;
  logic          rx_empty, tx_empty;
  logic          rx_pop, tx_push, tx_pop, rx_flush, tx_flush;

  assign busy       = (rel_left_q != '0);
  assign op         = pa_op_e'(cmd_wdata_i[7:5]);
  assign cmd_v      = cmd_we_i && !busy && !tx_done_i;
  assign tx_evt     = tx_done_i && !busy;
  assign rx_v       = rx_alloc_req_i && !busy && !cmd_we_i && !tx_done_i;
  assign host_alloc = cmd_v && (op == OP_ALLOC);
  assign n_host     = 6'(cmd_wdata_i[4:0]) + 6'd1;
  assign n_rx       = 6'(rx_alloc_pages_i) + 6'd1;
  assign n_sel      = host_alloc ? n_host : n_rx;
  assign grant      = (host_alloc || rx_v) && found;
  assign pnr_ok     = pnr_q < 7'(NUM_PAGES);

  pa_run_finder #(.NUM_PAGES(NUM_PAGES), .PW(PW)) u_find (
    .used_i (used_q),
    .n_i    (n_sel),
    .found_o(found),
    .start_o(start)
  );

  always_comb begin
    for (int k = 0; k < NUM_PAGES; k++)
      claim[k] = grant && k >= int'(start) && k < int'(start) + int'(n_sel);
    used_cnt = '0;
    for (int k = 0; k < NUM_PAGES; k++) used_cnt = used_cnt + CW'(used_q[k]);
  end
  assign free_cnt = CW'(NUM_PAGES) - used_cnt;

  // release sources are mutually exclusive by construction of cmd_v / tx_evt
  always_comb begin
    rel_start = 1'b0;
    rel_pkt   = '0;
    if (cmd_v && op == OP_RX_RELEASE && !rx_empty) begin
      rel_start = 1'b1;
      rel_pkt   = rx_head;
    end else if (cmd_v && op == OP_FREE_PNR && pnr_ok) begin
      rel_start = 1'b1;
      rel_pkt   = pnr_q[PW-1:0];
    end else if (tx_evt && auto_release_i && !tx_empty) begin
      rel_start = 1'b1;
      rel_pkt   = tx_head;
    end
  end

  assign rx_pop   = cmd_v && (op == OP_RX_REMOVE || op == OP_RX_RELEASE);
  assign tx_push  = cmd_v && op == OP_TX_ENQ && pnr_ok;
  assign tx_pop   = tx_evt;
  assign rx_flush = cmd_v && op == OP_RESET;
  assign tx_flush = cmd_v && (op == OP_RESET || op == OP_TX_RESET);

  pa_pkt_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_rxq (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_v && found), .data_i(start),
    .pop_i(rx_pop), .head_o(rx_head), .empty_o(rx_empty)
  );

  pa_pkt_fifo #(.DEPTH(NUM_PAGES), .W(PW)) u_txq (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push), .data_i(pnr_q[PW-1:0]),
    .pop_i(tx_pop), .head_o(tx_head), .empty_o(tx_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q     <= '0;
      rel_pg_q   <= '0;
      rel_left_q <= '0;
      for (int i = 0; i < NUM_PAGES; i++) cnt_q[i] <= '0;
    end else if (rx_flush) begin
      used_q <= '0;
      for (int i = 0; i < NUM_PAGES; i++) cnt_q[i] <= '0;
    end else if (busy) begin
      used_q[rel_pg_q] <= 1'b0;
      rel_pg_q         <= rel_pg_q + PW'(1);
      rel_left_q       <= rel_left_q - CW'(1);
    end else if (rel_start) begin
      rel_pg_q       <= rel_pkt;
      rel_left_q     <= cnt_q[rel_pkt];
      cnt_q[rel_pkt] <= '0;
    end else if (grant) begin
      used_q       <= used_q | claim;
      cnt_q[start] <= CW'(n_sel);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= 8'h80;
      pnr_q <= '0;
      ack_q <= 1'b0;
      ok_q  <= 1'b0;
      pkt_q <= '0;
    end else begin
      if (host_alloc) res_q <= found ? {1'b0, 7'(start)} : 8'h80;
      else if (rx_flush) res_q <= 8'h80;
      if (pnr_we_i) pnr_q <= pnr_wdata_i;
      ack_q <= rx_alloc_req_i;
      ok_q  <= rx_v && found;
      pkt_q <= start;
    end
  end

  assign cmd_status_o   = {7'b0, busy};
  assign alloc_result_o = res_q;
  assign mem_info_o     = {8'(free_cnt), 8'(NUM_PAGES)};
  assign queue_heads_o  = {rx_empty, rx_empty ? 7'd0 : 7'(rx_head),
                           tx_empty, tx_empty ? 7'd0 : 7'(tx_head)};
  assign rx_alloc_ack_o = ack_q;
  assign rx_alloc_ok_o  = ok_q;
  assign rx_alloc_pkt_o = ok_q ? 7'(pkt_q) : 7'd0;

  // R2
  alloc_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_alloc && !found) |=> (alloc_result_o == 8'h80) && $stable(used_q));
  // R5
  rel_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (mem_info_o[15:8] == $past(mem_info_o[15:8]) + 8'd1));
  // R6
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(alloc_result_o));
  // R3
  free_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_info_o[15:8] <= mem_info_o[7:0]);
  // R12
  rx_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_alloc_req_i |=> rx_alloc_ack_o);
endmodule

// File: tb/sim_pa_alloc_top.sv
module sim_pa_alloc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_wdata = '0;
  logic        pnr_we = 1'b0;
  logic [6:0]  pnr_wdata = '0;
  logic [7:0]  status, result;
  logic [15:0] heads, info;
  logic        rx_req = 1'b0;
  logic [4:0]  rx_pages = '0;
  logic        rx_ack, rx_ok;
  logic [6:0]  rx_pkt;
  logic        tx_done = 1'b0;
  logic        auto_rel = 1'b0;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pa_alloc_top #(.NUM_PAGES(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .pnr_we_i(pnr_we), .pnr_wdata_i(pnr_wdata),
    .cmd_status_o(status), .alloc_result_o(result),
    .queue_heads_o(heads), .mem_info_o(info),
    .rx_alloc_req_i(rx_req), .rx_alloc_pages_i(rx_pages),
    .rx_alloc_ack_o(rx_ack), .rx_alloc_ok_o(rx_ok), .rx_alloc_pkt_o(rx_pkt),
    .tx_done_i(tx_done), .auto_release_i(auto_rel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [4:0] low);
    cmd_we = 1'b1;
    cmd_wdata = {op, low};
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic set_pnr(input logic [6:0] p);
    pnr_we = 1'b1;
    pnr_wdata = p;
    @(negedge clk);
    pnr_we = 1'b0;
  endtask

  task automatic rx_alloc(input logic [4:0] pm1);
    rx_req = 1'b1;
    rx_pages = pm1;
    @(negedge clk);
    rx_req = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R3 reset info", info, 16'h1010);
    chk("R4 reset heads", heads, 16'h8080);
    chk("R1 reset result", {8'h0, result}, 16'h0080);
    chk("R5 reset idle", {8'h0, status}, 16'h0000);
  endtask

  task automatic t_host_alloc;
    cmd(3'd1, 5'd0);
    chk("R1 alloc 1 page", {8'h0, result}, 16'h0000);
    cmd(3'd1, 5'd2);
    chk("R1 alloc 3 pages", {8'h0, result}, 16'h0001);
    chk("R3 free after allocs", info, 16'h0c10);
  endtask

  task automatic t_rx_port;
    rx_alloc(5'd1);
    chk("R12 rx grant", {rx_ack, rx_ok, 7'd0, rx_pkt}, {2'b11, 7'd0, 7'd4});
    chk("R4 rx head", heads, 16'h0480);
    chk("R12 rx pages taken", info, 16'h0a10);
  endtask

  task automatic t_free_busy;
    set_pnr(7'd1);
    cmd(3'd5, 5'd0);
    chk("R5 busy set", {8'h0, status}, 16'h0001);
    chk("R5 no page yet", info, 16'h0a10);
    cmd(3'd1, 5'd0);  // issued while busy
    chk("R6 alloc ignored", {8'h0, result}, 16'h0001);
    chk("R5 one page back", info, 16'h0b10);
    @(negedge clk);
    chk("R5 two pages back", info, 16'h0c10);
    chk("R5 still busy", {8'h0, status}, 16'h0001);
    @(negedge clk);
    chk("R5 done", info, 16'h0d10);
    chk("R5 busy clear", {8'h0, status}, 16'h0000);
  endtask

  task automatic t_first_fit;
    cmd(3'd1, 5'd3);
    chk("R1 first fit 4 pages", {8'h0, result}, 16'h0006);
    cmd(3'd1, 5'd1);
    chk("R1 first fit 2 pages", {8'h0, result}, 16'h0001);
    chk("R3 free after fits", info, 16'h0710);
  endtask

  task automatic t_alloc_fail;
    cmd(3'd1, 5'd7);
    chk("R2 fail flag", {8'h0, result}, 16'h0080);
    chk("R2 free unchanged", info, 16'h0710);
  endtask

  task automatic t_rx_remove;
    cmd(3'd3, 5'd0);
    chk("R7 remove pops", heads, 16'h8080);
    chk("R7 remove keeps pages", info, 16'h0710);
    set_pnr(7'd4);
    cmd(3'd5, 5'd0);
    repeat (2) @(negedge clk);
    chk("R5 free removed pkt", info, 16'h0910);
  endtask

  task automatic t_tx_queue;
    set_pnr(7'd6);
    cmd(3'd6, 5'd0);
    set_pnr(7'd0);
    cmd(3'd6, 5'd0);
    chk("R8 tx head first", heads, 16'h8006);
    auto_rel = 1'b1;
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk("R9 tx pop order", heads, 16'h8000);
    chk("R9 auto release busy", {8'h0, status}, 16'h0001);
    repeat (4) @(negedge clk);
    chk("R9 auto release freed", info, 16'h0d10);
    auto_rel = 1'b0;
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk("R9 no release when low", info, 16'h0d10);
    chk("R9 tx empty", heads, 16'h8080);
  endtask

  task automatic t_tx_reset;
    set_pnr(7'd1);
    cmd(3'd6, 5'd0);
    chk("R8 enqueue", heads, 16'h8001);
    cmd(3'd7, 5'd0);
    chk("R10 tx queue flushed", heads, 16'h8080);
    chk("R10 pages kept", info, 16'h0d10);
  endtask

  task automatic t_rx_release;
    rx_alloc(5'd2);
    chk("R12 rx second grant", {9'd0, rx_pkt}, 16'h0003);
    chk("R12 rx free count", info, 16'h0a10);
    cmd(3'd4, 5'd0);
    chk("R7 release pops", heads, 16'h8080);
    repeat (3) @(negedge clk);
    chk("R7 release frees", info, 16'h0d10);
  endtask

  task automatic t_full_reset;
    set_pnr(7'd0);
    cmd(3'd6, 5'd0);
    rx_alloc(5'd0);
    cmd(3'd2, 5'd0);
    chk("R11 all free", info, 16'h1010);
    chk("R11 queues empty", heads, 16'h8080);
  endtask

  task automatic t_rx_deny;
    rx_alloc(5'd16);
    chk("R12 too large denied", {14'd0, rx_ack, rx_ok}, 16'h0002);
    chk("R12 deny free same", info, 16'h1010);
    cmd_we = 1'b1;
    cmd_wdata = 8'h00;
    rx_req = 1'b1;
    rx_pages = 5'd0;
    @(negedge clk);
    cmd_we = 1'b0;
    rx_req = 1'b0;
    chk("R12 blocked by command", {14'd0, rx_ack, rx_ok}, 16'h0002);
  endtask

  task automatic t_cmd_vs_txdone;
    cmd(3'd1, 5'd0);
    chk("R1 alloc after reset", {8'h0, result}, 16'h0000);
    cmd_we = 1'b1;
    cmd_wdata = {3'd1, 5'd0};
    tx_done = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    tx_done = 1'b0;
    chk("R6 command dropped with completion", info, 16'h0f10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_host_alloc();
    t_rx_port();
    t_free_busy();
    t_first_fit();
    t_alloc_fail();
    t_rx_remove();
    t_tx_queue();
    t_tx_reset();
    t_rx_release();
    t_full_reset();
    t_rx_deny();
    t_cmd_vs_txdone();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule